// File: doc/BRIEF.md
# Floating-Point Exponent Extractor

This unit takes one IEEE-754 operand, either single or double precision, and returns the signed binary exponent E that puts the operand's magnitude in the form M·2^E with 0.5 ≤ M < 1. A shader or vector pipeline uses it as the integer half of a fraction/exponent split. The mantissa half is not part of this unit. Each accepted operand produces one 32-bit two's-complement result one clock later.

The operand arrives on a 64-bit bus. A precision select picks the format. Subnormal operands are normalised by locating their highest set fraction bit. Zeros, infinities and NaNs each give a fixed result of 0, whatever their sign.

The operand may be marked with an absolute-value modifier, a negate modifier, or both. These alter only the sign of the value being evaluated, so they never alter the result. One datapath serves both precisions: the single-precision fraction is zero-extended into the double-width leading-one search.

Top module: `fpexp_unit`

## Requirements
- R1: For a single-precision operand with biased exponent field b in 1..254 (field at bits 30:23, fraction at bits 22:0), the result is b - 126. Examples: 1024.0 gives 11, 2^-10 gives -9, and the largest finite single value gives 128.
- R2: For a double-precision operand with biased exponent field b in 1..2046 (field at bits 62:52, fraction at bits 51:0), the result is b - 1022. The largest finite double value gives 1024.
- R3: The operand's sign bit (bit 31 for single, bit 63 for double) has no effect on the result. Both -1024.0 and +1024.0 give 11.
- R4: An exponent field of zero with a fraction of zero (+0.0 or -0.0) gives 0 in either precision.
- R5: An exponent field of all ones (infinity of either sign, or any NaN) gives 0 in either precision.
- R6: A single-precision subnormal whose highest set fraction bit is at index p (0..22) gives p - 148. The smallest positive single subnormal gives -148.
- R7: A double-precision subnormal whose highest set fraction bit is at index p (0..51) gives p - 1073. The smallest positive double subnormal gives -1073.
- R8: In single-precision mode (`is_double` = 0), bits 63:32 of the operand bus are ignored.
- R9: Neither `mod_abs` nor `mod_neg`, alone or together, changes the result.
- R10: `exp_out` and `out_valid` are registered. `out_valid` equals `in_valid` from the previous cycle. `exp_out` loads only when `in_valid` is high and otherwise holds its value. A synchronous active-high `rst` clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand valid strobe |
| operand | input | 64 | Operand bus; single precision uses bits 31:0 |
| is_double | input | 1 | 1 = double precision, 0 = single precision |
| mod_abs | input | 1 | Absolute-value source modifier |
| mod_neg | input | 1 | Negate source modifier |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| exp_out | output | 32 | Signed exponent result |

## Verification
The hardest cases to reach are the subnormals. Each possible position of the highest set fraction bit must appear on its own, with random bits below it and nothing above it, for all 23 single and 52 double positions. The bench builds these operands directly from the bit index, and it drives random upper-half garbage, random signs and random modifiers on every single-precision operand. It also sweeps every biased exponent value of both formats, so both ends of the normal range and the neighbouring zero and all-ones codes are each visited.

// File: rtl/fpexp_pkg.sv
package fpexp_pkg;

    localparam int OP_W       = 64;
    localparam int RES_W      = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int IDX_W      = $clog2(DP_FRAC_W);

    // offsets turning a biased field or a leading-one index into E
    localparam int SP_NORM_ADJ = (1 << (SP_EXP_W - 1)) - 2;   // 126
    localparam int DP_NORM_ADJ = (1 << (DP_EXP_W - 1)) - 2;   // 1022
    localparam int SP_SUB_ADJ  = SP_NORM_ADJ + SP_FRAC_W - 1; // 148
    localparam int DP_SUB_ADJ  = DP_NORM_ADJ + DP_FRAC_W - 1; // 1073

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_SUBNORM = 2'd1,
        CLS_NORMAL  = 2'd2,
        CLS_SPECIAL = 2'd3
    } opclass_t;

    typedef struct packed {
        opclass_t              cls;
        logic                  dbl;
        logic [DP_EXP_W-1:0]   bexp;
        logic [DP_FRAC_W-1:0]  frac;
    } fields_t;

    // index of highest set bit; 0 when the vector is empty
    function automatic logic [IDX_W-1:0] top_one(input logic [DP_FRAC_W-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < DP_FRAC_W; i++) begin
            if (v[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/fpexp_split.sv
module fpexp_split
    import fpexp_pkg::*;
(
    input  logic [OP_W-1:0] operand,
    input  logic            is_double,
    output fields_t         fields
);
    localparam int SP_PAD = DP_FRAC_W - SP_FRAC_W;
    localparam int EX_PAD = DP_EXP_W - SP_EXP_W;

    logic [DP_EXP_W-1:0]  bexp;
    logic [DP_FRAC_W-1:0] frac;
    logic                 exp_ones;

    always_comb begin
        if (is_double) begin
            bexp     = operand[DP_FRAC_W +: DP_EXP_W];
            frac     = operand[DP_FRAC_W-1:0];
            exp_ones = &operand[DP_FRAC_W +: DP_EXP_W];
        end else begin
            bexp     = {{EX_PAD{1'b0}}, operand[SP_FRAC_W +: SP_EXP_W]};
            frac     = {{SP_PAD{1'b0}}, operand[SP_FRAC_W-1:0]};
            exp_ones = &operand[SP_FRAC_W +: SP_EXP_W];
        end
    end

    always_comb begin
        fields.dbl  = is_double;
        fields.bexp = bexp;
        fields.frac = frac;
        if (exp_ones)
            fields.cls = CLS_SPECIAL;
        else if (bexp != '0)
            fields.cls = CLS_NORMAL;
        else if (frac != '0)
            fields.cls = CLS_SUBNORM;
        else
            fields.cls = CLS_ZERO;
    end

endmodule

// File: rtl/fpexp_lead.sv
module fpexp_lead
    import fpexp_pkg::*;
(
    input  logic [DP_FRAC_W-1:0] frac,
    output logic [IDX_W-1:0]     idx
);
    always_comb idx = top_one(frac);
endmodule

// File: rtl/fpexp_calc.sv
module fpexp_calc
    import fpexp_pkg::*;
(
    input  fields_t                 fields,
    input  logic [IDX_W-1:0]        idx,
    output logic signed [RES_W-1:0] result
);
    logic signed [RES_W-1:0] norm_adj;
    logic signed [RES_W-1:0] sub_adj;

    always_comb begin
        norm_adj = fields.dbl ? RES_W'(DP_NORM_ADJ) : RES_W'(SP_NORM_ADJ);
        sub_adj  = fields.dbl ? RES_W'(DP_SUB_ADJ)  : RES_W'(SP_SUB_ADJ);
        unique case (fields.cls)
            CLS_NORMAL:  result = signed'(RES_W'(fields.bexp)) - norm_adj;
            CLS_SUBNORM: result = signed'(RES_W'(idx)) - sub_adj;
            default:     result = '0;
        endcase
    end
endmodule

// File: rtl/fpexp_unit.sv
module fpexp_unit
    import fpexp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [OP_W-1:0]         operand,
    input  logic                    is_double,
    input  logic                    mod_abs,
    input  logic                    mod_neg,
    output logic                    out_valid,
    output logic signed [RES_W-1:0] exp_out
);
    // Modifiers act on the sign only; the result depends on magnitude,
    // so they do not enter the datapath.
    fields_t                 fields;
    logic [IDX_W-1:0]        lead_idx;
    logic signed [RES_W-1:0] next_exp;

    fpexp_split u_split (
        .operand   (operand),
        .is_double (is_double),
        .fields    (fields)
    );

    fpexp_lead u_lead (
        .frac (fields.frac),
        .idx  (lead_idx)
    );

    fpexp_calc u_calc (
        .fields (fields),
        .idx    (lead_idx),
        .result (next_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            exp_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) exp_out <= next_exp;
        end
    end

endmodule

// File: rtl/fpexp_unit_chk.sv
module fpexp_unit_chk
    import fpexp_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [OP_W-1:0]         operand,
    input logic                    is_double,
    input logic                    mod_abs,
    input logic                    mod_neg,
    input logic                    out_valid,
    input logic signed [RES_W-1:0] exp_out
);
    logic sp_ones, dp_ones, sp_zero, dp_zero, sp_norm, dp_norm;
    assign sp_ones = &operand[30:23];
    assign dp_ones = &operand[62:52];
    assign sp_zero = operand[30:0] == '0;
    assign dp_zero = operand[62:0] == '0;
    assign sp_norm = !sp_ones && operand[30:23] != '0;
    assign dp_norm = !dp_ones && operand[62:52] != '0;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(exp_out));
    // R5
    special_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (is_double ? dp_ones : sp_ones) |=> exp_out == 0);
    // R4
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (is_double ? dp_zero : sp_zero) |=> exp_out == 0);
    // R1
    sp_normal_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !is_double && sp_norm |=>
        exp_out == $signed({24'b0, $past(operand[30:23])}) - 32'sd126);
    // R2
    dp_normal_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_double && dp_norm |=>
        exp_out == $signed({21'b0, $past(operand[62:52])}) - 32'sd1022);
    // R9
    mod_range_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (mod_abs || mod_neg) |=>
        exp_out >= -32'sd1073 && exp_out <= 32'sd1024);
endmodule

bind fpexp_unit fpexp_unit_chk u_chk (.*);

// File: tb/sim_fpexp_unit.sv
`timescale 1ns/1ps
module sim_fpexp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        is_double = 1'b0;
    logic        mod_abs = 1'b0;
    logic        mod_neg = 1'b0;
    logic        out_valid;
    logic signed [31:0] exp_out;

    int checks = 0;
    int fails  = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    fpexp_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .is_double(is_double), .mod_abs(mod_abs), .mod_neg(mod_neg),
        .out_valid(out_valid), .exp_out(exp_out)
    );

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic check(input string req, input int got, input int exp_v);
        checks++;
        if (got != exp_v) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp_v);
        end
    endtask

    // drive at a falling edge, result sampled at the next falling edge
    task automatic run(input logic [63:0] op, input logic dbl,
                       input logic ab, input logic ng,
                       input int exp_v, input string req);
        in_valid  = 1'b1;
        operand   = op;
        is_double = dbl;
        mod_abs   = ab;
        mod_neg   = ng;
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(exp_out), exp_v);
    endtask

    task automatic run_sp(input logic [31:0] w, input int exp_v, input string req);
        logic [63:0] r;
        seed = step(seed);
        r = seed;
        run({r[63:32], (w & 32'h7FFF_FFFF) | {r[5], 31'b0}}, 1'b0, r[0], r[1], exp_v, req);
    endtask

    task automatic run_dp(input logic [63:0] w, input int exp_v, input string req);
        logic [63:0] r;
        seed = step(seed);
        r = seed;
        run({r[7], w[62:0]}, 1'b1, r[0], r[1], exp_v, req);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] r;
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 reset valid", int'(out_valid), 0);
        check("R10 reset exp", int'(exp_out), 0);
        rst = 1'b0;

        // known values
        run(64'h0000_0000_4480_0000, 1'b0, 1'b0, 1'b0, 11, "R1 1024");
        run(64'h0000_0000_3A80_0000, 1'b0, 1'b0, 1'b0, -9, "R1 2^-10");
        run(64'h0000_0000_7F7F_FFFF, 1'b0, 1'b0, 1'b0, 128, "R1 max single");
        run(64'h7FEF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1024, "R2 max double");
        run(64'h4090_0000_0000_0000, 1'b1, 1'b0, 1'b0, 11, "R2 1024 double");
        run(64'h0000_0000_C480_0000, 1'b0, 1'b0, 1'b0, 11, "R3 -1024 single");
        run(64'hC090_0000_0000_0000, 1'b1, 1'b0, 1'b0, 11, "R3 -1024 double");
        run(64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, -148, "R6 min single");
        run(64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0, -1073, "R7 min double");
        run(64'h0000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 0, "R4 +0 single");
        run(64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0, 0, "R4 -0 single");
        run(64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 0, "R4 -0 double");
        run(64'h0000_0000_7F80_0000, 1'b0, 1'b0, 1'b0, 0, "R5 +inf single");
        run(64'h0000_0000_FF80_0000, 1'b0, 1'b0, 1'b0, 0, "R5 -inf single");
        run(64'h0000_0000_7FC0_0000, 1'b0, 1'b0, 1'b0, 0, "R5 nan single");
        run(64'h7FF0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 0, "R5 +inf double");
        run(64'hFFF0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 0, "R5 -inf double");
        run(64'h7FF8_0000_0000_0001, 1'b1, 1'b0, 1'b0, 0, "R5 nan double");
        // R8 upper half garbage in single mode
        run(64'hFFFF_FFFF_4480_0000, 1'b0, 1'b0, 1'b0, 11, "R8 upper ones");
        run(64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 1'b0, 0, "R8 upper inf pattern");
        // R9 modifiers
        run(64'h0000_0000_4480_0000, 1'b0, 1'b1, 1'b0, 11, "R9 abs");
        run(64'h0000_0000_4480_0000, 1'b0, 1'b0, 1'b1, 11, "R9 neg");
        run(64'hC090_0000_0000_0000, 1'b1, 1'b1, 1'b1, 11, "R9 neg abs");
        run(64'h0000_0000_0000_0001, 1'b1, 1'b1, 1'b1, -1073, "R9 neg abs sub");

        // R10 hold while idle
        in_valid = 1'b0;
        operand  = 64'h0000_0000_3F80_0000;
        is_double = 1'b0;
        @(negedge clk);
        check("R10 idle valid", int'(out_valid), 0);
        check("R10 idle hold", int'(exp_out), -1073);
        @(negedge clk);
        check("R10 idle hold 2", int'(exp_out), -1073);

        // sweep single exponents (R1, R4, R5, R8, R9 with random sign, mods)
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 2; k++) begin
                logic [22:0] f;
                int ev;
                seed = step(seed);
                r = seed;
                f = (k == 0) ? 23'd0 : r[40:18];
                if (e == 255) ev = 0;
                else if (e == 0 && f == 0) ev = 0;
                else if (e == 0) continue;
                else ev = e - 126;
                run_sp({1'b0, 8'(e), f}, ev, (e == 255) ? "R5 sp sweep" :
                       (e == 0) ? "R4 sp sweep" : "R1 sp sweep");
            end
        end
        // sweep double exponents (R2, R3, R4, R5)
        for (int e = 0; e < 2048; e++) begin
            logic [51:0] f;
            int ev;
            seed = step(seed);
            r = seed;
            f = (e[0]) ? r[51:0] : 52'd0;
            if (e == 0) f = 52'd0;
            if (e == 2047) ev = 0;
            else if (e == 0) ev = 0;
            else ev = e - 1022;
            run_dp({1'b0, 11'(e), f}, ev, (e == 2047) ? "R5 dp sweep" :
                   (e == 0) ? "R4 dp sweep" : "R2 dp sweep");
        end
        // single subnormals, every leading-one position (R6)
        for (int p = 0; p < 23; p++) begin
            logic [22:0] f;
            seed = step(seed);
            r = seed;
            f = (23'd1 << p) | (r[22:0] & ((23'd1 << p) - 23'd1));
            run_sp({9'b0, f}, p - 148, "R6 sp subnormal");
        end
        // double subnormals, every leading-one position (R7)
        for (int p = 0; p < 52; p++) begin
            logic [51:0] f;
            seed = step(seed);
            r = seed;
            f = (52'd1 << p) | (r[51:0] & ((52'd1 << p) - 52'd1));
            run_dp({12'b0, f}, p - 1073, "R7 dp subnormal");
        end

        // R10 reset mid-run clears state
        run(64'h0000_0000_4480_0000, 1'b0, 1'b0, 1'b0, 11, "R10 pre-reset");
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid reset valid", int'(out_valid), 0);
        check("R10 mid reset exp", int'(exp_out), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule